// File: doc/BRIEF.md
# Serial Frame Transmitter with Host Holding Register

This block serialises one byte at a time onto an asynchronous transmit line. The host writes a byte through a single-cycle write strobe into an 8-bit holding register. The host can always read that register back. An accepted byte is copied into a shift register, which sends one frame on the line: a low start bit, then 7 or 8 data bits with the least significant bit first, then a high stop bit. The bit rate comes from an external one-cycle tick. Every bit, including the start bit, begins on a tick and lasts until the next tick, so the first tick after a write opens the start bit.

A write is accepted only when the module enable and the transmit enable are both high and no frame is in flight. The busy output tells the host when a write will not be taken. A write made while busy is discarded and reported on a one-cycle error pulse. A write made while either enable is low is silently ignored. When the stop bit ends, busy drops and a one-cycle completion interrupt pulses in the same cycle. The write port is a plain strobe, not a valid/ready channel: there is no back-pressure, and a refused byte is never retried by the block.

Top module: `uart_tx_buf`

## Requirements
- R1: After reset `buf_q` reads 0xFF, `txd` is high, and `busy`, `tx_irq` and `wr_err` are low.
- R2: A strobe is accepted when `mod_en`, `tx_en` and `wr_stb` are high and `busy` is low. After the clock edge that samples an accepted strobe, `buf_q` equals the written byte and `busy` is high.
- R3: A strobe taken while `mod_en` or `tx_en` is low has no effect: `buf_q`, `busy` and `txd` keep their values, and `wr_err` stays low.
- R4: A frame is one low start bit, then the data bits least significant first, then one high stop bit. Each bit is placed on `txd` by the edge that samples a `bit_tick`, beginning with the first tick after acceptance.
- R5: With `len7`=1 the frame carries bits 6..0 of the byte (7 data bits). With `len7`=0 it carries bits 7..0 (8 data bits).
- R6: The edge that samples the tick ending the stop bit clears `busy` and raises `tx_irq`. `tx_irq` stays high for exactly one cycle.
- R7: A strobe taken while enabled and `busy` leaves `buf_q` and the frame in progress untouched. It raises `wr_err` for exactly the one cycle after that strobe.
- R8: `txd` is high whenever `busy` is low, and it is high in any cycle in which `mod_en` or `tx_en` is low. If either enable drops during a frame, the frame is abandoned and `busy` is low from the next cycle.
- R9: `tx_irq` is raised only by the end of a complete frame. An abandoned frame produces no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_en | input | 1 | Module enable |
| tx_en | input | 1 | Transmit enable |
| len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| bit_tick | input | 1 | One-cycle bit-rate tick |
| wr_stb | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte written with the strobe |
| txd | output | 1 | Serial transmit line, idles high |
| busy | output | 1 | A frame is pending or in flight; writes are not allowed |
| tx_irq | output | 1 | One-cycle pulse at the end of a frame |
| wr_err | output | 1 | One-cycle pulse after a write refused because of busy |
| buf_q | output | 8 | Holding register read-back |

## Verification
The bench checks every bit position of frames in both data lengths. For the 7-bit case it uses a byte whose bit 7 differs from the stop level, so a design that sends an eighth data bit puts a low level where the stop bit belongs, and fires the interrupt one tick late. It writes while busy and checks the holding register and the error pulse: a design that lets the write through corrupts the read-back value, and one that forgets the pulse stays silent. It drops the transmit enable in the middle of the data bits and then keeps ticking: a design that does not abandon the frame keeps the line low or later raises a stray interrupt.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int TX_DATA_W = 8;
  localparam logic [TX_DATA_W-1:0] TX_BUF_RST = '1;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_ARM,
    TX_START,
    TX_DATA,
    TX_STOP
  } tx_state_e;
endpackage

// File: rtl/uart_tx_hostbuf.sv
module uart_tx_hostbuf #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              busy,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              load,
  output logic [DATA_W-1:0] buf_q,
  output logic              wr_err
);
  // a strobe is taken only when enabled and idle
  assign load = wr_stb && run && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= RST_VAL;
      wr_err <= 1'b0;
    end else begin
      if (load) buf_q <= wr_data;
      wr_err <= wr_stb && run && busy;
    end
  end
endmodule

// File: rtl/uart_tx_bitseq.sv
module uart_tx_bitseq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              len7,
  input  logic              bit_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_FULL  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

  tx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  logic              line;

  assign last_idx = len7 ? LAST_SHORT : LAST_FULL;
  assign busy     = (state != TX_IDLE);

  always_comb begin
    unique case (state)
      TX_START: line = 1'b0;
      TX_DATA:  line = shreg[0];
      default:  line = 1'b1;
    endcase
  end

  // the line is forced to the idle level whenever the block is disabled
  assign txd = run ? line : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      shreg <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        state <= TX_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          TX_IDLE: if (load) begin
            state <= TX_ARM;
            shreg <= load_data;
            cnt   <= '0;
          end
          TX_ARM:   if (bit_tick) state <= TX_START;
          TX_START: if (bit_tick) state <= TX_DATA;
          TX_DATA:  if (bit_tick) begin
            shreg <= {1'b0, shreg[DATA_W-1:1]};
            if (cnt == last_idx) begin
              state <= TX_STOP;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          TX_STOP: if (bit_tick) begin
            state <= TX_IDLE;
            done  <= 1'b1;
          end
          default: state <= TX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_buf.sv
module uart_tx_buf
  import uart_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mod_en,
  input  logic                 tx_en,
  input  logic                 len7,
  input  logic                 bit_tick,
  input  logic                 wr_stb,
  input  logic [TX_DATA_W-1:0] wr_data,
  output logic                 txd,
  output logic                 busy,
  output logic                 tx_irq,
  output logic                 wr_err,
  output logic [TX_DATA_W-1:0] buf_q
);
  logic run;
  logic load;

  assign run = mod_en && tx_en;

  uart_tx_hostbuf #(.DATA_W(TX_DATA_W), .RST_VAL(TX_BUF_RST)) u_hostbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .busy    (busy),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .load    (load),
    .buf_q   (buf_q),
    .wr_err  (wr_err)
  );

  uart_tx_bitseq #(.DATA_W(TX_DATA_W)) u_bitseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .len7      (len7),
    .bit_tick  (bit_tick),
    .load      (load),
    .load_data (wr_data),
    .txd       (txd),
    .busy      (busy),
    .done      (tx_irq)
  );
endmodule

// File: rtl/uart_tx_buf_chk.sv
module uart_tx_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mod_en,
  input logic       tx_en,
  input logic       wr_stb,
  input logic [7:0] wr_data,
  input logic       txd,
  input logic       busy,
  input logic       tx_irq,
  input logic       wr_err,
  input logic [7:0] buf_q
);
  // R2
  accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && mod_en && tx_en && !busy) |=> (busy && buf_q == $past(wr_data)));

  // R3
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && mod_en && tx_en && !busy) |=> $stable(buf_q));

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  // R6
  irq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (!busy && $past(busy)));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_stb && mod_en && tx_en && busy));

  // R8
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R8
  off_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_en && tx_en) |-> txd);

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_en && tx_en) |=> !busy);
endmodule

bind uart_tx_buf uart_tx_buf_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mod_en  (mod_en),
  .tx_en   (tx_en),
  .wr_stb  (wr_stb),
  .wr_data (wr_data),
  .txd     (txd),
  .busy    (busy),
  .tx_irq  (tx_irq),
  .wr_err  (wr_err),
  .buf_q   (buf_q)
);

// File: tb/uart_tx_buf_bench.sv
module uart_tx_buf_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mod_en = 1'b0;
  logic       tx_en = 1'b0;
  logic       len7 = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, busy, tx_irq, wr_err;
  logic [7:0] buf_q;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_tx_buf u_uart_tx_buf (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .tx_en(tx_en), .len7(len7),
    .bit_tick(bit_tick), .wr_stb(wr_stb), .wr_data(wr_data), .txd(txd),
    .busy(busy), .tx_irq(tx_irq), .wr_err(wr_err), .buf_q(buf_q)
  );

  // {mod_en, tx_en, len7, data}
  localparam logic [10:0] VEC [7] = '{
    {3'b110, 8'hA5}, {3'b111, 8'h35}, {3'b100, 8'h3C}, {3'b110, 8'h81},
    {3'b010, 8'h77}, {3'b111, 8'h4E}, {3'b110, 8'h6B}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write(input logic [7:0] d);
    wr_stb = 1'b1; wr_data = d;
    step();
    wr_stb = 1'b0;
  endtask

  task automatic tick();
    bit_tick = 1'b1;
    step();
    bit_tick = 1'b0;
  endtask

  task automatic gap();
    for (int k = 0; k < 3; k++) step();
  endtask

  task automatic send_frame(input logic [7:0] d, input logic l7);
    int nb;
    nb = l7 ? 7 : 8;
    len7 = l7;
    write(d);
    chk("R2 buf", buf_q, d);
    chk("R2 busy", {7'd0, busy}, 8'd1);
    gap();
    chk("R4 idle before tick", {7'd0, txd}, 8'd1);
    tick();
    chk("R4 start", {7'd0, txd}, 8'd0);
    gap();
    for (int i = 0; i < nb; i++) begin
      tick();
      chk("R4 R5 data bit", {7'd0, txd}, {7'd0, d[i]});
      gap();
    end
    tick();
    chk("R5 stop", {7'd0, txd}, 8'd1);
    chk("R6 busy in stop", {7'd0, busy}, 8'd1);
    chk("R9 no irq early", {7'd0, tx_irq}, 8'd0);
    gap();
    tick();
    chk("R6 irq", {7'd0, tx_irq}, 8'd1);
    chk("R6 busy clear", {7'd0, busy}, 8'd0);
    step();
    chk("R6 irq one cycle", {7'd0, tx_irq}, 8'd0);
  endtask

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    step(); step();
    // R1
    chk("R1 buf", buf_q, 8'hFF);
    chk("R1 txd", {7'd0, txd}, 8'd1);
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 irq", {7'd0, tx_irq}, 8'd0);
    chk("R1 err", {7'd0, wr_err}, 8'd0);
    rst_n = 1'b1;
    step();

    foreach (VEC[v]) begin
      mod_en = VEC[v][10];
      tx_en  = VEC[v][9];
      step();
      if (VEC[v][10] && VEC[v][9]) begin
        send_frame(VEC[v][7:0], VEC[v][8]);
      end else begin
        prev = buf_q;
        write(VEC[v][7:0]);
        chk("R3 buf kept", buf_q, prev);
        chk("R3 busy", {7'd0, busy}, 8'd0);
        chk("R3 no err", {7'd0, wr_err}, 8'd0);
        tick();
        chk("R3 R8 line high", {7'd0, txd}, 8'd1);
      end
    end

    // R7: write while busy
    mod_en = 1'b1; tx_en = 1'b1; len7 = 1'b0;
    step();
    write(8'h5A);
    write(8'hC3);
    chk("R7 err pulse", {7'd0, wr_err}, 8'd1);
    chk("R7 buf kept", buf_q, 8'h5A);
    step();
    chk("R7 err one cycle", {7'd0, wr_err}, 8'd0);
    tick();
    chk("R7 frame intact start", {7'd0, txd}, 8'd0);
    tick();
    chk("R7 frame intact bit0", {7'd0, txd}, 8'd0);
    tick();
    chk("R7 frame intact bit1", {7'd0, txd}, 8'd1);

    // R8 / R9: abort mid-frame
    tx_en = 1'b0;
    #1;
    chk("R8 line forced high", {7'd0, txd}, 8'd1);
    step();
    chk("R8 busy cleared", {7'd0, busy}, 8'd0);
    chk("R9 no irq on abort", {7'd0, tx_irq}, 8'd0);
    tx_en = 1'b1;
    for (int t = 0; t < 12; t++) begin
      tick();
      chk("R9 no stray irq", {7'd0, tx_irq}, 8'd0);
      chk("R8 idle line", {7'd0, txd}, 8'd1);
    end

    // back-to-back frame after completion, read-back
    send_frame(8'h96, 1'b0);
    chk("R2 readback", buf_q, 8'h96);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule